// File: doc/BRIEF.md
# Speculative Cache Line Tracker

This block holds the transactional state of one processor in a system where code runs as speculative transactions. For each line of a small direct-mapped L1 it keeps a valid bit, a tag, a read bit set by speculative loads and a modified bit set by speculative stores. Store addresses are queued in a local write buffer. None of them leave the block before commit. When the processor asks to commit, the block requests permission from a system arbiter. Once permission is granted, it streams the buffered addresses out as one commit packet with one address per cycle, marking the first and last beats.

A snoop port carries, at most once per cycle, an address committed by another processor. A snooped address that matches a valid line invalidates that line. If the line was read by the open transaction, the transaction is dead: every read and modified bit is cleared, the write buffer is emptied and a restart pulse tells the processor to roll back. While the block already holds commit permission, such matches only invalidate. Coherence has no ownership states.

Top module: `spec_line_tracker`

## Requirements
- R1: After reset, valid_bits_o, rd_bits_o and mod_bits_o are zero, st_ready_o is 1, overflow_o, arb_req_o, pkt_valid_o, restart_o and done_o are 0.
- R2: An address maps to line index addr[IDX_W-1:0] with tag addr[ADDR_W-1:IDX_W]. A load sets the valid and read bits of its line and an accepted store sets the valid and modified bits, both visible the cycle after the request.
- R3: A commit_i pulse raises arb_req_o on the next cycle. The cycle after arb_gnt_i is sampled high, the packet starts with one buffered address per cycle in store order, pkt_sop_o on the first beat and pkt_eop_o on the last.
- R4: pkt_valid_o stays low except during a granted commit broadcast, so buffered stores are not visible before commit.
- R5: A snooped address that hits a valid line with its read bit set, while no commit grant is held, gives a one-cycle restart_o pulse on the next cycle. At that point all read and modified bits are zero, the write buffer is empty and arb_req_o is low.
- R6: A snooped address hitting a valid line clears that line's valid bit on the next cycle, even when its read bit is clear. Such a hit without a read bit, or a tag mismatch, gives no restart.
- R7: With WB_DEPTH stores buffered, overflow_o is 1 and st_ready_o is 0, and further stores are not taken until commit.
- R8: The cycle after the last beat, done_o pulses for one cycle. On the following cycle all read and modified bits are zero and the write buffer is empty.
- R9: A read-bit hit during the block's own broadcast causes no restart, and the packet completes intact.
- R10: A grant with an empty write buffer gives done_o on the next cycle with no packet beats.
- R11: st_ready_o is 0 from a commit request until the cycle after done_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ld_valid_i | input | 1 | Speculative load |
| ld_addr_i | input | ADDR_W | Load line address |
| st_valid_i | input | 1 | Speculative store request |
| st_addr_i | input | ADDR_W | Store line address |
| st_ready_o | output | 1 | Store accepted this cycle |
| overflow_o | output | 1 | Write buffer full |
| commit_i | input | 1 | Processor requests commit |
| arb_req_o | output | 1 | Commit permission request |
| arb_gnt_i | input | 1 | Commit permission granted |
| pkt_valid_o | output | 1 | Commit packet beat |
| pkt_sop_o | output | 1 | First beat of packet |
| pkt_eop_o | output | 1 | Last beat of packet |
| pkt_addr_o | output | ADDR_W | Committed address |
| snp_valid_i | input | 1 | Snooped remote commit address |
| snp_addr_i | input | ADDR_W | Snooped address |
| restart_o | output | 1 | Violation, roll back transaction |
| done_o | output | 1 | Commit finished |
| valid_bits_o | output | 2**IDX_W | Per-line valid bits |
| rd_bits_o | output | 2**IDX_W | Per-line read bits |
| mod_bits_o | output | 2**IDX_W | Per-line modified bits |

## Verification
The bench uses the default ADDR_W=12, IDX_W=3 and WB_DEPTH=4. The shallow buffer makes a full buffer and refused stores reachable after four stores. Eight lines let the tests keep read-marked lines, store-only lines and tag-mismatch lines apart. The bench injects snoops while a request is pending and in the middle of a broadcast, so both the case where a violation is taken and the case where it is ignored are exercised.

// File: rtl/slt_pkg.sv
package slt_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_REQ,
    ST_SEND,
    ST_DONE
  } commit_state_e;
endpackage

// File: rtl/slt_line_state.sv
module slt_line_state #(
  parameter int IDX_W = 3,
  parameter int TAG_W = 9,
  localparam int LINES = 2 ** IDX_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ld_en_i,
  input  logic [IDX_W-1:0] ld_idx_i,
  input  logic [TAG_W-1:0] ld_tag_i,
  input  logic             st_en_i,
  input  logic [IDX_W-1:0] st_idx_i,
  input  logic [TAG_W-1:0] st_tag_i,
  input  logic             snp_en_i,
  input  logic [IDX_W-1:0] snp_idx_i,
  input  logic [TAG_W-1:0] snp_tag_i,
  input  logic             clear_i,
  output logic             snp_rd_hit_o,
  output logic [LINES-1:0] valid_o,
  output logic [LINES-1:0] rd_o,
  output logic [LINES-1:0] mod_o
);
  logic [LINES-1:0] rd_hit;

  for (genvar i = 0; i < LINES; i++) begin : g_line
    logic             v_q, r_q, m_q;
    logic [TAG_W-1:0] t_q;
    logic             snp_hit, ld_hit, st_hit;

    assign snp_hit   = snp_en_i && (snp_idx_i == IDX_W'(i)) && v_q && (t_q == snp_tag_i);
    assign ld_hit    = ld_en_i && (ld_idx_i == IDX_W'(i));
    assign st_hit    = st_en_i && (st_idx_i == IDX_W'(i));
    assign rd_hit[i] = snp_hit && r_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        v_q <= 1'b0;
        r_q <= 1'b0;
        m_q <= 1'b0;
        t_q <= '0;
      end else begin
        if (clear_i) begin
          r_q <= 1'b0;
          m_q <= 1'b0;
        end
        if (snp_hit) begin
          v_q <= 1'b0;
          r_q <= 1'b0;
          m_q <= 1'b0;
        end
        // a local access after the snoop refills the line
        if (ld_hit) begin
          v_q <= 1'b1;
          r_q <= 1'b1;
          t_q <= ld_tag_i;
        end
        if (st_hit) begin
          v_q <= 1'b1;
          m_q <= 1'b1;
          t_q <= st_tag_i;
        end
      end
    end

    assign valid_o[i] = v_q;
    assign rd_o[i]    = r_q;
    assign mod_o[i]   = m_q;

    p_snoop_inval_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      snp_hit && !ld_hit && !st_hit |=> !v_q);
  end

  assign snp_rd_hit_o = |rd_hit;
endmodule

// File: rtl/slt_write_buf.sv
module slt_write_buf #(
  parameter int ADDR_W   = 12,
  parameter int WB_DEPTH = 4,
  localparam int PTR_W   = $clog2(WB_DEPTH),
  localparam int CNT_W   = $clog2(WB_DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              push_i,
  input  logic [ADDR_W-1:0] push_addr_i,
  input  logic              flush_i,
  input  logic              start_i,
  input  logic              adv_i,
  output logic              full_o,
  output logic              empty_o,
  output logic              last_o,
  output logic [ADDR_W-1:0] head_addr_o
);
  logic [ADDR_W-1:0] mem_q [WB_DEPTH];
  logic [CNT_W-1:0]  cnt_q;
  logic [PTR_W-1:0]  rd_ptr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q    <= '0;
      rd_ptr_q <= '0;
    end else begin
      if (flush_i)     cnt_q <= '0;
      else if (push_i) cnt_q <= cnt_q + CNT_W'(1);
      if (start_i)     rd_ptr_q <= '0;
      else if (adv_i)  rd_ptr_q <= rd_ptr_q + PTR_W'(1);
    end
  end

  always_ff @(posedge clk_i) begin
    if (push_i) mem_q[cnt_q[PTR_W-1:0]] <= push_addr_i;
  end

  assign full_o      = (cnt_q == CNT_W'(WB_DEPTH));
  assign empty_o     = (cnt_q == '0);
  assign last_o      = (CNT_W'(rd_ptr_q) + CNT_W'(1) == cnt_q);
  assign head_addr_o = mem_q[rd_ptr_q];

  p_push_not_full_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |-> !full_o);
  p_adv_not_empty_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adv_i |-> !empty_o);
endmodule

// File: rtl/slt_commit_ctrl.sv
module slt_commit_ctrl
  import slt_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          commit_i,
  input  logic          gnt_i,
  input  logic          viol_i,
  input  logic          wb_empty_i,
  input  logic          wb_last_i,
  output commit_state_e state_o,
  output logic          viol_take_o,
  output logic          start_o,
  output logic          adv_o,
  output logic          sop_o,
  output logic          done_o,
  output logic          clear_o
);
  commit_state_e state_q, state_d;
  logic          first_q;

  // a violation counts only until permission is held
  assign viol_take_o = viol_i && (state_q == ST_IDLE || state_q == ST_REQ);
  assign start_o     = (state_q == ST_REQ) && gnt_i && !viol_take_o && !wb_empty_i;
  assign adv_o       = (state_q == ST_SEND);
  assign sop_o       = adv_o && first_q;
  assign done_o      = (state_q == ST_DONE);
  assign clear_o     = viol_take_o || done_o;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (commit_i && !viol_take_o) state_d = ST_REQ;
      ST_REQ: begin
        if (viol_take_o) state_d = ST_IDLE;
        else if (gnt_i)  state_d = wb_empty_i ? ST_DONE : ST_SEND;
      end
      ST_SEND: if (wb_last_i) state_d = ST_DONE;
      ST_DONE: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      first_q <= 1'b0;
    end else begin
      state_q <= state_d;
      if (start_o)    first_q <= 1'b1;
      else if (adv_o) first_q <= 1'b0;
    end
  end

  assign state_o = state_q;

  p_done_after_send_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_SEND) && wb_last_i |=> done_o);
endmodule

// File: rtl/spec_line_tracker.sv
module spec_line_tracker
  import slt_pkg::*;
#(
  parameter int ADDR_W   = 12,
  parameter int IDX_W    = 3,
  parameter int WB_DEPTH = 4,
  localparam int TAG_W   = ADDR_W - IDX_W,
  localparam int LINES   = 2 ** IDX_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ld_valid_i,
  input  logic [ADDR_W-1:0] ld_addr_i,
  input  logic              st_valid_i,
  input  logic [ADDR_W-1:0] st_addr_i,
  output logic              st_ready_o,
  output logic              overflow_o,
  input  logic              commit_i,
  output logic              arb_req_o,
  input  logic              arb_gnt_i,
  output logic              pkt_valid_o,
  output logic              pkt_sop_o,
  output logic              pkt_eop_o,
  output logic [ADDR_W-1:0] pkt_addr_o,
  input  logic              snp_valid_i,
  input  logic [ADDR_W-1:0] snp_addr_i,
  output logic              restart_o,
  output logic              done_o,
  output logic [LINES-1:0]  valid_bits_o,
  output logic [LINES-1:0]  rd_bits_o,
  output logic [LINES-1:0]  mod_bits_o
);
  commit_state_e state;
  logic viol_raw, viol_take, start, adv, clear;
  logic wb_full, wb_empty, wb_last, push, restart_q;

  assign st_ready_o = (state == ST_IDLE) && !wb_full;
  assign push       = st_valid_i && st_ready_o && !viol_take;

  slt_line_state #(.IDX_W(IDX_W), .TAG_W(TAG_W)) i_lines (
    .clk_i, .rst_ni,
    .ld_en_i      (ld_valid_i && !clear),
    .ld_idx_i     (ld_addr_i[IDX_W-1:0]),
    .ld_tag_i     (ld_addr_i[ADDR_W-1:IDX_W]),
    .st_en_i      (push),
    .st_idx_i     (st_addr_i[IDX_W-1:0]),
    .st_tag_i     (st_addr_i[ADDR_W-1:IDX_W]),
    .snp_en_i     (snp_valid_i),
    .snp_idx_i    (snp_addr_i[IDX_W-1:0]),
    .snp_tag_i    (snp_addr_i[ADDR_W-1:IDX_W]),
    .clear_i      (clear),
    .snp_rd_hit_o (viol_raw),
    .valid_o      (valid_bits_o),
    .rd_o         (rd_bits_o),
    .mod_o        (mod_bits_o)
  );

  slt_write_buf #(.ADDR_W(ADDR_W), .WB_DEPTH(WB_DEPTH)) i_wbuf (
    .clk_i, .rst_ni,
    .push_i      (push),
    .push_addr_i (st_addr_i),
    .flush_i     (clear),
    .start_i     (start),
    .adv_i       (adv),
    .full_o      (wb_full),
    .empty_o     (wb_empty),
    .last_o      (wb_last),
    .head_addr_o (pkt_addr_o)
  );

  slt_commit_ctrl i_ctrl (
    .clk_i, .rst_ni,
    .commit_i    (commit_i),
    .gnt_i       (arb_gnt_i),
    .viol_i      (viol_raw),
    .wb_empty_i  (wb_empty),
    .wb_last_i   (wb_last),
    .state_o     (state),
    .viol_take_o (viol_take),
    .start_o     (start),
    .adv_o       (adv),
    .sop_o       (pkt_sop_o),
    .done_o      (done_o),
    .clear_o     (clear)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) restart_q <= 1'b0;
    else         restart_q <= viol_take;
  end

  assign restart_o   = restart_q;
  assign overflow_o  = wb_full;
  assign arb_req_o   = (state == ST_REQ);
  assign pkt_valid_o = adv;
  assign pkt_eop_o   = adv && wb_last;

  p_restart_clean_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_o |-> (rd_bits_o == '0) && (mod_bits_o == '0) && !overflow_o && !arb_req_o);
  p_done_clears_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> (rd_bits_o == '0) && (mod_bits_o == '0) && !overflow_o);
  p_no_restart_in_send_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pkt_valid_o |=> !restart_o);
  p_eop_closes_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pkt_valid_o && pkt_eop_o |=> !pkt_valid_o);
  p_no_store_in_commit_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    arb_req_o || pkt_valid_o || done_o |-> !st_ready_o);
endmodule

// File: tb/test_spec_line_tracker.sv
module test_spec_line_tracker;
  localparam int ADDR_W = 12;
  localparam int IDX_W  = 3;
  localparam int DEPTH  = 4;
  localparam int LINES  = 2 ** IDX_W;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ld_valid = 0, st_valid = 0, commit = 0, gnt = 0, snp_valid = 0;
  logic [ADDR_W-1:0] ld_addr = '0, st_addr = '0, snp_addr = '0;
  logic st_ready, overflow, arb_req, pkt_valid, pkt_sop, pkt_eop, restart, done;
  logic [ADDR_W-1:0] pkt_addr;
  logic [LINES-1:0] valid_bits, rd_bits, mod_bits;

  int checks = 0, fails = 0, beats = 0, beat_idx = 0;
  bit finished = 0;
  logic [ADDR_W-1:0] exp_q[$];

  always #2.5 clk = ~clk;

  spec_line_tracker #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .WB_DEPTH(DEPTH)) i_spec_line_tracker (
    .clk_i(clk), .rst_ni(rst_n),
    .ld_valid_i(ld_valid), .ld_addr_i(ld_addr),
    .st_valid_i(st_valid), .st_addr_i(st_addr), .st_ready_o(st_ready), .overflow_o(overflow),
    .commit_i(commit), .arb_req_o(arb_req), .arb_gnt_i(gnt),
    .pkt_valid_o(pkt_valid), .pkt_sop_o(pkt_sop), .pkt_eop_o(pkt_eop), .pkt_addr_o(pkt_addr),
    .snp_valid_i(snp_valid), .snp_addr_i(snp_addr),
    .restart_o(restart), .done_o(done),
    .valid_bits_o(valid_bits), .rd_bits_o(rd_bits), .mod_bits_o(mod_bits)
  );

  function automatic logic [ADDR_W-1:0] mk(input int tag, input int idx);
    return {(ADDR_W-IDX_W)'(tag), IDX_W'(idx)};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic do_load(input logic [ADDR_W-1:0] a);
    ld_valid = 1; ld_addr = a; tick(); ld_valid = 0;
  endtask

  task automatic do_store(input logic [ADDR_W-1:0] a);
    if (st_ready) exp_q.push_back(a);
    st_valid = 1; st_addr = a; tick(); st_valid = 0;
  endtask

  task automatic do_snoop(input logic [ADDR_W-1:0] a);
    snp_valid = 1; snp_addr = a; tick(); snp_valid = 0;
  endtask

  task automatic request_and_grant();
    commit = 1; tick(); commit = 0;
    chk("R3 arb_req", arb_req, 1);
    chk("R11 st_ready in commit", st_ready, 0);
    gnt = 1; tick(); gnt = 0;
    beats = 0; beat_idx = 0;
  endtask

  task automatic finish_commit(input int n);
    int guard = 0;
    while (!done && guard < 20) begin tick(); guard++; end
    chk("R8 done pulse", done, 1);
    chk("R3 beat count", beats, n);
    tick();
    chk("R8 done one cycle", done, 0);
    chk("R8 rd cleared", rd_bits, 0);
    chk("R8 mod cleared", mod_bits, 0);
    chk("R8 buffer empty", overflow, 0);
    chk("R11 st_ready after done", st_ready, 1);
  endtask

  // monitor: scoreboard of committed addresses
  always @(negedge clk) begin
    if (rst_n && pkt_valid) begin
      beats++;
      if (exp_q.size() == 0) begin
        checks++; fails++;
        $display("FAIL R4: unexpected beat %0h, expected none", pkt_addr);
      end else begin
        logic [ADDR_W-1:0] e;
        e = exp_q.pop_front();
        chk("R3 packet addr", pkt_addr, e);
        chk("R3 sop", pkt_sop, beat_idx == 0);
        chk("R3 eop", pkt_eop, exp_q.size() == 0);
      end
      beat_idx++;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    tick(); tick();
    chk("R1 valid", valid_bits, 0);
    chk("R1 rd", rd_bits, 0);
    chk("R1 mod", mod_bits, 0);
    chk("R1 st_ready", st_ready, 1);
    chk("R1 flags", {overflow, arb_req, pkt_valid, restart, done}, 0);
    rst_n = 1; tick();

    // R2: load and stores mark lines
    do_load(mk(8'h20, 1));
    chk("R2 rd bit", rd_bits, 8'h02);
    chk("R2 valid bit", valid_bits, 8'h02);
    do_store(mk(8'h11, 2));
    do_store(mk(8'h12, 3));
    chk("R2 mod bits", mod_bits, 8'h0C);
    chk("R4 no beat before commit", pkt_valid, 0);
    request_and_grant();
    finish_commit(2);

    // R5: violation while idle
    do_load(mk(8'h30, 2));
    do_store(mk(8'h31, 3));
    do_snoop(mk(8'h30, 2));
    chk("R5 restart", restart, 1);
    chk("R5 rd cleared", rd_bits, 0);
    chk("R5 mod cleared", mod_bits, 0);
    exp_q.delete();
    tick();
    chk("R5 restart one cycle", restart, 0);
    // R10: flushed buffer commits empty
    commit = 1; tick(); commit = 0;
    gnt = 1; beats = 0; beat_idx = 0; tick(); gnt = 0;
    chk("R10 done immediately", done, 1);
    chk("R10 no beats", beats, 0);
    tick();

    // R5: violation while request pending
    do_load(mk(8'h40, 5));
    do_store(mk(8'h41, 6));
    commit = 1; tick(); commit = 0;
    chk("R3 arb_req pending", arb_req, 1);
    do_snoop(mk(8'h40, 5));
    chk("R5 restart in req", restart, 1);
    chk("R5 arb_req dropped", arb_req, 0);
    exp_q.delete();
    tick();

    // R6: store-only line invalidated, no restart; tag mismatch ignored
    do_store(mk(8'h50, 4));
    do_load(mk(8'h51, 5));
    do_snoop(mk(8'h50, 4));
    chk("R6 line invalidated", valid_bits[4], 0);
    chk("R6 no restart", restart, 0);
    do_snoop(mk(8'h77, 5));
    chk("R6 mismatch no restart", restart, 0);
    chk("R6 mismatch keeps line", {valid_bits[5], rd_bits[5]}, 2'b11);
    request_and_grant();
    finish_commit(1);

    // R7: overflow
    for (int i = 0; i < DEPTH; i++) do_store(mk(8'h60 + i, i));
    chk("R7 overflow", overflow, 1);
    chk("R7 st_ready low", st_ready, 0);
    do_store(mk(8'h6F, 7));
    chk("R7 extra store dropped", mod_bits[7], 0);
    request_and_grant();
    finish_commit(DEPTH);

    // R9: read hit during own broadcast is ignored
    do_load(mk(8'h70, 6));
    do_store(mk(8'h71, 0));
    do_store(mk(8'h72, 1));
    do_store(mk(8'h73, 2));
    request_and_grant();
    do_snoop(mk(8'h70, 6));
    chk("R9 no restart", restart, 0);
    tick();
    chk("R9 still no restart", restart, 0);
    finish_commit(3);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule